// File: doc/BRIEF.md
# Host Memory Address Decoder with Hole Recovery

This block sits at the front of one memory controller on a shared host bus. For every memory request it looks at the 36-bit host address and the access direction. It decides whether this controller should answer. If it answers, it reports which DRAM row holds the data and the address inside DRAM. Requests it does not claim are left to another agent on the bus, for example the bridge that covers everything above installed memory.

Software programs the decoder through a narrow write port. The programmable state is a base address, one cumulative limit per DRAM row in 4 MB steps, three hole descriptors in 64 KB steps, and access attributes. The main memory window and the fixed 64 KB boot-code window at F0000h–FFFFFh each have their own read and write attributes. A hole of 1 MB or more that lies wholly below an address is subtracted from that address. The DRAM behind the hole therefore reappears above the top of this controller's memory. The decoder also counts claimed transactions that have not yet completed. It stalls new requests while four are outstanding.

Top module: `mcd_addr_decode`

## Requirements
- R1: After reset, every attribute, hole enable, row limit and the base are zero, so no request is claimed, and `req_ready` is 1.
- R2: Outside the boot window, a read is claimed only if attribute bit 0 (main read) is set, and a write only if attribute bit 1 (main write) is set. The attributes are written at select 1.
- R3: For addresses F0000h–FFFFFh, a read is claimed only if attribute bit 2 (boot read) is set, and a write only if bit 3 (boot write) is set. The main bits do not apply there.
- R4: Row limits are written at selects 8..11 in 4 MB units and are cumulative. `rsp_row` is the lowest row i for which the effective address is below limit_i × 4 MB.
- R5: An address below base × 4 MB (select 0), or one whose effective address is at or above the last row limit, is not claimed.
- R6: A hole whose size is at least 1 MB and whose end is at or below the address has its size subtracted. The effective address is the host address minus base × 4 MB minus those sizes. Hole g has its start at select 2+g (bits 19:0 in 64 KB units, bit 31 the enable) and its size at select 5+g (bits 19:0 in 64 KB units).
- R7: A hole smaller than 1 MB is never subtracted.
- R8: An address inside any enabled hole is not claimed, whatever its size.
- R9: `rsp_valid` rises exactly one cycle after each accepted request (`req_valid` and `req_ready`), including unclaimed ones. `rsp_claim`, `rsp_row` and `rsp_eff_addr` are valid with it.
- R10: While four claimed transactions are outstanding, `req_ready` is 0 and no request is accepted. A `done_pulse` frees one slot on the next cycle.
- R11: A claim and a `done_pulse` in the same cycle leave the outstanding count unchanged.
- R12: A configuration write takes effect from the next cycle. A request accepted in the same cycle as the write is decoded with the old settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 36 | Host byte address |
| req_ready | output | 1 | Request can be accepted this cycle |
| done_pulse | input | 1 | One claimed transaction completed |
| rsp_valid | output | 1 | Decode result present |
| rsp_claim | output | 1 | This controller answers the request |
| rsp_row | output | 2 | DRAM row of a claimed request |
| rsp_eff_addr | output | 36 | Address inside DRAM after hole removal |

## Verification
Each decode result is registered once and is due at the first clock edge after acceptance. The bench drives a request at a falling edge and reads the result at the next falling edge, which puts one rising edge in between. `req_ready` follows the outstanding count, which changes on the same edge as the result. The bench therefore reads ready at that same falling edge after a claim or a completion. A configuration write is driven at a falling edge together with a request, to show that the next edge applies the old settings to that request and the new settings to the one after it.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int NUM_GAPS      = 3;
  localparam int SEL_BASE      = 0;
  localparam int SEL_ATTR      = 1;
  localparam int SEL_GAP_START = 2;
  localparam int SEL_GAP_SIZE  = SEL_GAP_START + NUM_GAPS;
  localparam int SEL_ROW       = SEL_GAP_SIZE + NUM_GAPS;

  typedef struct packed {
    logic boot_we;
    logic boot_re;
    logic main_we;
    logic main_re;
  } win_attr_t;
endpackage

// File: rtl/mcd_cfg_regs.sv
module mcd_cfg_regs
  import mcd_pkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int NUM_ROWS = 4,
  parameter int DATA_W   = 32,
  parameter int SEL_W    = 4,
  parameter int LIM_W    = 14,
  parameter int GAP_W    = 20
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [SEL_W-1:0]                     wr_sel,
  input  logic [DATA_W-1:0]                    wr_data,
  output logic [LIM_W-1:0]                     base_o,
  output win_attr_t                            attr_o,
  output logic [NUM_GAPS-1:0]                  gap_en_o,
  output logic [NUM_GAPS-1:0][GAP_W-1:0]       gap_start_o,
  output logic [NUM_GAPS-1:0][GAP_W-1:0]       gap_size_o,
  output logic [NUM_ROWS-1:0][LIM_W-1:0]       row_lim_o
);
  logic [LIM_W-1:0]                base_q, base_d;
  win_attr_t                       attr_q, attr_d;
  logic [NUM_GAPS-1:0]             en_q, en_d;
  logic [NUM_GAPS-1:0][GAP_W-1:0]  start_q, start_d;
  logic [NUM_GAPS-1:0][GAP_W-1:0]  size_q, size_d;
  logic [NUM_ROWS-1:0][LIM_W-1:0]  lim_q, lim_d;
  logic                            unused_wdata;

  assign unused_wdata = ^wr_data;

  always_comb begin
    base_d  = base_q;
    attr_d  = attr_q;
    en_d    = en_q;
    start_d = start_q;
    size_d  = size_q;
    lim_d   = lim_q;
    if (wr_en) begin
      if (wr_sel == SEL_W'(SEL_BASE)) base_d = wr_data[LIM_W-1:0];
      if (wr_sel == SEL_W'(SEL_ATTR)) attr_d = win_attr_t'(wr_data[3:0]);
      for (int g = 0; g < NUM_GAPS; g++) begin
        if (wr_sel == SEL_W'(SEL_GAP_START + g)) begin
          en_d[g]    = wr_data[DATA_W-1];
          start_d[g] = wr_data[GAP_W-1:0];
        end
        if (wr_sel == SEL_W'(SEL_GAP_SIZE + g)) size_d[g] = wr_data[GAP_W-1:0];
      end
      for (int r = 0; r < NUM_ROWS; r++) begin
        if (wr_sel == SEL_W'(SEL_ROW + r)) lim_d[r] = wr_data[LIM_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      attr_q  <= '0;
      en_q    <= '0;
      start_q <= '0;
      size_q  <= '0;
      lim_q   <= '0;
    end else if (wr_en) begin
      base_q  <= base_d;
      attr_q  <= attr_d;
      en_q    <= en_d;
      start_q <= start_d;
      size_q  <= size_d;
      lim_q   <= lim_d;
    end
  end

  assign base_o      = base_q;
  assign attr_o      = attr_q;
  assign gap_en_o    = en_q;
  assign gap_start_o = start_q;
  assign gap_size_o  = size_q;
  assign row_lim_o   = lim_q;

  assert_cfg_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(attr_q) && $stable(base_q) && $stable(lim_q));
endmodule

// File: rtl/mcd_gap_unit.sv
module mcd_gap_unit #(
  parameter int GAP_W     = 20,
  parameter int MIN_PAGES = 16
) (
  input  logic [GAP_W-1:0] page_i,
  input  logic             en_i,
  input  logic [GAP_W-1:0] start_i,
  input  logic [GAP_W-1:0] size_i,
  output logic             inside_o,
  output logic [GAP_W-1:0] hole_o
);
  logic [GAP_W:0] end_p;
  logic           recoverable;
  logic           below;

  always_comb begin
    end_p       = {1'b0, start_i} + {1'b0, size_i};
    recoverable = en_i && (size_i >= GAP_W'(MIN_PAGES));
    below       = ({1'b0, page_i} >= end_p);
    inside_o    = en_i && (page_i >= start_i) && !below;
    hole_o      = (recoverable && below) ? size_i : '0;
  end
endmodule

// File: rtl/mcd_row_sel.sv
module mcd_row_sel #(
  parameter int LIM_W    = 14,
  parameter int NUM_ROWS = 4,
  parameter int IDX_W    = 2
) (
  input  logic [LIM_W-1:0]                eff_hi_i,
  input  logic [NUM_ROWS-1:0][LIM_W-1:0]  lim_i,
  output logic                            hit_o,
  output logic [IDX_W-1:0]                row_o
);
  localparam int CNT_W = $clog2(NUM_ROWS + 1);

  logic [NUM_ROWS-1:0] past;
  logic [CNT_W-1:0]    cnt;

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_cmp
    assign past[i] = (eff_hi_i >= lim_i[i]);
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NUM_ROWS; i++) cnt = cnt + CNT_W'(past[i]);
  end

  assign hit_o = !past[NUM_ROWS-1];
  assign row_o = IDX_W'(cnt);
endmodule

// File: rtl/mcd_txn_ctr.sv
module mcd_txn_ctr #(
  parameter int MAX_OUT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  output logic ready_o
);
  localparam int CNT_W = $clog2(MAX_OUT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_ok;

  always_comb begin
    dec_ok = dec_i && (cnt_q != '0);
    cnt_d  = cnt_q;
    if (inc_i && !dec_ok)      cnt_d = cnt_q + 1'b1;
    else if (!inc_i && dec_ok) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (inc_i || dec_ok)  cnt_q <= cnt_d;
  end

  assign ready_o = (cnt_q < CNT_W'(MAX_OUT));

  assert_cnt_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_OUT));
  assert_full_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(MAX_OUT)) && !dec_i |=> !ready_o);
  assert_same_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i && dec_i && (cnt_q != '0) |=> $stable(cnt_q));
endmodule

// File: rtl/mcd_addr_decode.sv
module mcd_addr_decode
  import mcd_pkg::*;
#(
  parameter int ADDR_W   = 36,
  parameter int NUM_ROWS = 4,
  parameter int MAX_OUT  = 4,
  parameter int DATA_W   = 32,
  localparam int SEL_W   = $clog2(SEL_ROW + NUM_ROWS),
  localparam int IDX_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              done_pulse,
  output logic              rsp_valid,
  output logic              rsp_claim,
  output logic [IDX_W-1:0]  rsp_row,
  output logic [ADDR_W-1:0] rsp_eff_addr
);
  localparam int ROW_SHIFT  = 22;
  localparam int PAGE_SHIFT = 16;
  localparam int LIM_W      = ADDR_W - ROW_SHIFT;
  localparam int GAP_W      = ADDR_W - PAGE_SHIFT;
  localparam int MIN_PAGES  = 1 << (20 - PAGE_SHIFT);
  localparam int BOOT_PAGE  = 'hF;
  localparam int SUM_W      = GAP_W + $clog2(NUM_GAPS) + 1;
  localparam int DIFF_W     = ADDR_W + 3;

  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  logic [LIM_W-1:0]                base;
  win_attr_t                       attr;
  logic [NUM_GAPS-1:0]             gap_en;
  logic [NUM_GAPS-1:0][GAP_W-1:0]  gap_start, gap_size, hole;
  logic [NUM_ROWS-1:0][LIM_W-1:0]  row_lim;
  logic [NUM_GAPS-1:0]             in_gap;

  mcd_cfg_regs #(
    .ADDR_W(ADDR_W), .NUM_ROWS(NUM_ROWS), .DATA_W(DATA_W),
    .SEL_W(SEL_W), .LIM_W(LIM_W), .GAP_W(GAP_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(cfg_wr_en), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata), .base_o(base), .attr_o(attr), .gap_en_o(gap_en),
    .gap_start_o(gap_start), .gap_size_o(gap_size), .row_lim_o(row_lim)
  );

  for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
    mcd_gap_unit #(.GAP_W(GAP_W), .MIN_PAGES(MIN_PAGES)) u_gap (
      .page_i(req_addr[ADDR_W-1:PAGE_SHIFT]), .en_i(gap_en[g]),
      .start_i(gap_start[g]), .size_i(gap_size[g]),
      .inside_o(in_gap[g]), .hole_o(hole[g])
    );
  end

  logic [SUM_W-1:0]  hole_sum;
  logic [DIFF_W-1:0] diff;
  logic [ADDR_W-1:0] eff;
  logic              row_hit, boot_hit, allowed, claim, accept;
  logic [IDX_W-1:0]  row;

  always_comb begin
    hole_sum = '0;
    for (int g = 0; g < NUM_GAPS; g++) hole_sum = hole_sum + SUM_W'(hole[g]);
    diff = DIFF_W'(req_addr)
         - DIFF_W'({base, {ROW_SHIFT{1'b0}}})
         - DIFF_W'({hole_sum, {PAGE_SHIFT{1'b0}}});
    eff  = diff[ADDR_W-1:0];
  end

  mcd_row_sel #(.LIM_W(LIM_W), .NUM_ROWS(NUM_ROWS), .IDX_W(IDX_W)) u_rows (
    .eff_hi_i(eff[ADDR_W-1:ROW_SHIFT]), .lim_i(row_lim),
    .hit_o(row_hit), .row_o(row)
  );

  always_comb begin
    boot_hit = (req_addr[ADDR_W-1:PAGE_SHIFT] == GAP_W'(BOOT_PAGE));
    if (boot_hit) allowed = req_write ? attr.boot_we : attr.boot_re;
    else          allowed = req_write ? attr.main_we : attr.main_re;
    claim  = allowed && row_hit && !diff[DIFF_W-1] && !(|in_gap);
    accept = req_valid && req_ready;
  end

  mcd_txn_ctr #(.MAX_OUT(MAX_OUT)) u_ctr (
    .clk(clk), .rst_n(rst_i_n), .inc_i(accept && claim),
    .dec_i(done_pulse), .ready_o(req_ready)
  );

  logic              v_q, v_d, c_q, c_d;
  logic [IDX_W-1:0]  row_q;
  logic [ADDR_W-1:0] eff_q;

  always_comb begin
    v_d = accept;
    c_d = accept && claim;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      v_q <= 1'b0;
      c_q <= 1'b0;
    end else begin
      v_q <= v_d;
      c_q <= c_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      row_q <= '0;
      eff_q <= '0;
    end else if (accept) begin
      row_q <= row;
      eff_q <= eff;
    end
  end

  assign rsp_valid    = v_q;
  assign rsp_claim    = c_q;
  assign rsp_row      = row_q;
  assign rsp_eff_addr = eff_q;

  assert_rsp_due_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && req_ready) |=> rsp_valid);
  assert_rsp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(req_valid && req_ready) |=> !rsp_valid);
  assert_claim_valid_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_claim |-> rsp_valid);
  assert_gap_noclaim_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && req_ready && (|in_gap)) |=> !rsp_claim);
  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && !req_ready) |=> !rsp_valid);
endmodule

// File: tb/tb_mcd_addr_decode.sv
module tb_mcd_addr_decode;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [3:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid, req_write, req_ready, done_pulse;
  logic [35:0] req_addr;
  logic        rsp_valid, rsp_claim;
  logic [1:0]  rsp_row;
  logic [35:0] rsp_eff_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mcd_addr_decode dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ready(req_ready), .done_pulse(done_pulse),
    .rsp_valid(rsp_valid), .rsp_claim(rsp_claim), .rsp_row(rsp_row),
    .rsp_eff_addr(rsp_eff_addr)
  );

  // {write, addr, claim, row, eff}; base 0, rows 8/16/16/32 MB,
  // hole A 8..10 MB (recovered), hole B 12..12.5 MB (too small)
  localparam int NV = 14;
  localparam logic [75:0] VECS [NV] = '{
    {1'b0, 36'h0_0000_0000, 1'b1, 2'd0, 36'h0_0000_0000},  // R4
    {1'b0, 36'h0_000F_8000, 1'b1, 2'd0, 36'h0_000F_8000},  // R3 boot read open
    {1'b1, 36'h0_000F_8000, 1'b0, 2'd0, 36'h0},            // R3 boot write closed
    {1'b1, 36'h0_000E_FFFF, 1'b1, 2'd0, 36'h0_000E_FFFF},  // R2 main write
    {1'b0, 36'h0_0080_0000, 1'b0, 2'd0, 36'h0},            // R8 hole start
    {1'b0, 36'h0_009F_FFFF, 1'b0, 2'd0, 36'h0},            // R8 hole end
    {1'b0, 36'h0_00A0_0000, 1'b1, 2'd1, 36'h0_0080_0000},  // R6
    {1'b1, 36'h0_00C4_0000, 1'b0, 2'd0, 36'h0},            // R8 small hole
    {1'b1, 36'h0_00C8_0000, 1'b1, 2'd1, 36'h0_00A8_0000},  // R7
    {1'b0, 36'h0_007F_FFFF, 1'b1, 2'd0, 36'h0_007F_FFFF},  // R4
    {1'b0, 36'h0_0120_0000, 1'b1, 2'd3, 36'h0_0100_0000},  // R4 empty row skipped
    {1'b0, 36'h0_021F_FFFF, 1'b1, 2'd3, 36'h0_01FF_FFFF},  // R6 recovered top
    {1'b0, 36'h0_0220_0000, 1'b0, 2'd0, 36'h0},            // R5 above top
    {1'b0, 36'hF_FFFF_0000, 1'b0, 2'd0, 36'h0}             // R5
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic do_req(input logic w, input logic [35:0] a, output logic v,
                        output logic c, output logic [1:0] r, output logic [35:0] e);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid; c = rsp_claim; r = rsp_row; e = rsp_eff_addr;
  endtask

  task automatic finish_one;
    @(negedge clk); done_pulse = 1'b1;
    @(negedge clk); done_pulse = 1'b0;
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic v, c;
    logic [1:0] r;
    logic [35:0] e;
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; done_pulse = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R1 ready after reset", req_ready, 1);
    chk("R1 no response after reset", rsp_valid, 0);
    do_req(1'b0, 36'h0, v, c, r, e);
    chk("R9 response to unclaimed", v, 1);
    chk("R1 read closed", c, 0);
    do_req(1'b1, 36'h0_000F_8000, v, c, r, e);
    chk("R1 boot write closed", c, 0);

    cfg(4'd8, 32'd2);  cfg(4'd9, 32'd4);  cfg(4'd10, 32'd4); cfg(4'd11, 32'd8);
    cfg(4'd2, 32'h8000_0080); cfg(4'd5, 32'h20);
    cfg(4'd3, 32'h8000_00C0); cfg(4'd6, 32'h08);
    cfg(4'd1, 32'b0111);

    for (int i = 0; i < NV; i++) begin
      logic [75:0] vec;
      vec = VECS[i];
      do_req(vec[75], vec[74:39], v, c, r, e);
      chk($sformatf("R9 vec %0d valid", i), v, 1);
      chk($sformatf("R2/R3/R5/R8 vec %0d claim", i), c, vec[38]);
      if (vec[38]) begin
        chk($sformatf("R4 vec %0d row", i), r, vec[37:36]);
        chk($sformatf("R6/R7 vec %0d eff", i), e, vec[35:0]);
        finish_one();
      end
    end

    cfg(4'd1, 32'b0010);
    do_req(1'b0, 36'h100, v, c, r, e);  chk("R2 main read closed", c, 0);
    do_req(1'b1, 36'h100, v, c, r, e);  chk("R2 main write open", c, 1);
    finish_one();
    cfg(4'd1, 32'b1000);
    do_req(1'b1, 36'h0_000F_8000, v, c, r, e);  chk("R3 boot write open", c, 1);
    finish_one();
    do_req(1'b0, 36'h0_000F_8000, v, c, r, e);  chk("R3 boot read closed", c, 0);
    do_req(1'b1, 36'h100, v, c, r, e);  chk("R2 main write closed", c, 0);

    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = 4'd1; cfg_wdata = 32'b0001;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 36'h100;
    @(negedge clk);
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    chk("R12 accepted with old settings", rsp_claim, 0);
    do_req(1'b0, 36'h100, v, c, r, e);  chk("R12 new settings next cycle", c, 1);
    finish_one();

    cfg(4'd0, 32'd1);
    do_req(1'b0, 36'h0_0010_0000, v, c, r, e);  chk("R5 below base", c, 0);
    do_req(1'b0, 36'h0_0040_0000, v, c, r, e);
    chk("R5 at base claim", c, 1);
    chk("R6 eff minus base", e, 36'h0);
    finish_one();

    for (int k = 0; k < 4; k++) begin
      chk("R10 ready before limit", req_ready, 1);
      do_req(1'b0, 36'h0_0040_0000, v, c, r, e);
      chk("R10 claim fills slot", c, 1);
    end
    chk("R10 full stalls", req_ready, 0);
    @(negedge clk); req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    chk("R10 held request not accepted", rsp_valid, 0);
    finish_one();
    chk("R10 completion frees slot", req_ready, 1);
    @(negedge clk); req_valid = 1'b1; done_pulse = 1'b1; req_addr = 36'h0_0040_0000;
    @(negedge clk); req_valid = 1'b0; done_pulse = 1'b0;
    chk("R11 claimed with completion", rsp_claim, 1);
    chk("R11 count unchanged", req_ready, 1);
    do_req(1'b0, 36'h0_0040_0000, v, c, r, e);
    chk("R11 one more fills", req_ready, 0);
    for (int k = 0; k < 4; k++) finish_one();
    chk("R10 drained", req_ready, 1);

    report();
  end
endmodule